// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Bank

This block holds one 32-bit pending register for each of up to sixteen processors. The registers sit behind a simple 32-bit word bus, and the page field of the address picks the processor. Software can read a processor's register, OR soft-interrupt bits into it, and clear bits from it. Routed hardware interrupt levels set and clear low bits of the same register.

For every processor the block finds the highest pending soft level. Only the upper fifteen bits count as soft levels. It then sends that level to the processor as a one-cycle request strobe. A processor that has an unacknowledged request gets no new strobe until it acknowledges the old one. After the acknowledge, any level that is still pending is offered again. The strobe also serves as the wake signal for a halted core.

Top module: `softirq_bank`

## Requirements
- R1: After reset every pending register reads zero, `bus_rdata` is zero and no `irq_valid` bit is set.
- R2: A read (`bus_rd`) with address bits [3:2] equal to 0 and bits [11:4] zero returns, in the next cycle, the pending register of the processor given by address bits [15:12]. Offsets 1, 2 and 3 read as zero.
- R3: A write to offset 2 ORs the write data, masked to bits 31..17, into the addressed processor's register.
- R4: A write to offset 1 clears the register bits named by the write data masked to bits 31..17. If data bit 14 is set, bit 31 is also cleared.
- R5: Writes to offsets 0 and 3, and any access with a nonzero address bit in [11:4], leave every register unchanged. Such reads return zero.
- R6: A hardware event (`hw_valid`) with level L in 1..15 sets bit L of the register of processor `hw_cpu` when `hw_assert` is 1 and clears it when `hw_assert` is 0. Level 0 has no effect.
- R7: The level carried with a request is the index of the highest set bit among bits 31..17, minus 16 (1..15). Bits 16..0 never cause a request. `irq_level` reads zero when no strobe is present.
- R8: A request is a single-cycle `irq_valid` pulse. No further pulse goes to that processor until its `irq_ack` has been seen.
- R9: After `irq_ack`, a soft level that is still pending is requested again one cycle later.
- R10: A request appears in the cycle after the register edge that made a soft level pending. It uses the register contents as of that edge.
- R11: Accesses and events for one processor never change another processor's register or requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 14 | Word address bits [15:2]: processor page in [15:12], offset in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` and held until the next read |
| hw_valid | input | 1 | Hardware level event strobe |
| hw_assert | input | 1 | 1 sets the level bit, 0 clears it |
| hw_cpu | input | 4 | Target processor of the hardware event |
| hw_level | input | 4 | Hardware level 0..15 |
| irq_ack | input | 16 | Per-processor acknowledge of an outstanding request |
| irq_valid | output | 16 | Per-processor request strobe |
| irq_level | output | 64 | Per-processor 4-bit request level, processor c in bits [4c+3:4c] |

## Verification
Random set and clear writes to a few processors make the upper bits vary densely. This separates priority selection, where only the top bit may win, from a mere any-bit-set test. Random acknowledges interleaved with pending levels separate correct gating from re-issue on every cycle or from loss of a level after an acknowledge. Directed cases single out the bit-14 alias in a clear and writes to offsets that must be ignored. They also cover hardware levels that must not raise a request, level zero, and the out-of-window address decode, where a mistake would only show as a wrong readback.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int DATA_W     = 32;
    localparam int LVL_W      = 4;
    localparam int SOFT_LO    = 17;
    localparam int ALIAS_BIT  = 14;
    localparam int PAGE_SHIFT = 12;
    localparam logic [DATA_W-1:0] SOFT_MASK = 32'hFFFE_0000;

    typedef enum logic [1:0] {
        OFF_PEND = 2'd0,
        OFF_CLR  = 2'd1,
        OFF_SET  = 2'd2,
        OFF_RSV  = 2'd3
    } reg_off_e;

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic              busy;
        logic              valid;
        logic [LVL_W-1:0]  level;
    } slot_st_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_st_t;
endpackage

// File: rtl/sirq_prio_enc.sv
module sirq_prio_enc #(
    parameter int W  = 15,
    parameter int LW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [LW-1:0] idx
);
    // Highest set bit, reported as position + 1; zero when nothing is set.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = LW'(i + 1);
        end
    end
endmodule

// File: rtl/sirq_cpu_slot.sv
module sirq_cpu_slot
    import sirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic              ack,
    output logic [DATA_W-1:0] pend,
    output logic              req_valid,
    output logic [LVL_W-1:0]  req_level
);
    localparam int SOFT_W = DATA_W - SOFT_LO;

    slot_st_t         st_d, st_q;
    logic [LVL_W-1:0] top_lvl;
    logic             issue;

    sirq_prio_enc #(.W(SOFT_W), .LW(LVL_W)) u_enc (
        .vec (st_q.pend[DATA_W-1:SOFT_LO]),
        .idx (top_lvl)
    );

    always_comb begin
        st_d       = st_q;
        issue      = (top_lvl != '0) && !st_q.busy;
        st_d.valid = issue;
        st_d.level = issue ? top_lvl : '0;
        st_d.busy  = issue | (st_q.busy & ~ack);
        st_d.pend  = (st_q.pend & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend      = st_q.pend;
    assign req_valid = st_q.valid;
    assign req_level = st_q.level;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    a_r8_gated_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !req_valid);
    a_r7_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_level != '0));
    a_r10_needs_soft_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($past(st_q.pend[DATA_W-1:SOFT_LO]) != '0));
    a_r4_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((pend & $past(clr_mask & ~set_mask)) == '0));
endmodule

// File: rtl/softirq_bank.sv
module softirq_bank
    import sirq_pkg::*;
#(
    parameter int CPU_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [PAGE_SHIFT+CPU_W-1:2]   bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic                          hw_valid,
    input  logic                          hw_assert,
    input  logic [CPU_W-1:0]              hw_cpu,
    input  logic [LVL_W-1:0]              hw_level,
    input  logic [(1<<CPU_W)-1:0]         irq_ack,
    output logic [(1<<CPU_W)-1:0]         irq_valid,
    output logic [(1<<CPU_W)*LVL_W-1:0]   irq_level
);
    localparam int NUM_CPU = 1 << CPU_W;
    localparam int ADDR_W  = PAGE_SHIFT + CPU_W;

    logic [DATA_W-1:0] set_m  [NUM_CPU];
    logic [DATA_W-1:0] clr_m  [NUM_CPU];
    logic [DATA_W-1:0] pend_w [NUM_CPU];
    logic              in_win;
    reg_off_e          off;
    logic [CPU_W-1:0]  page;
    logic [DATA_W-1:0] soft_clr;
    logic [DATA_W-1:0] hw_bit;
    bus_st_t           bus_d, bus_q;

    always_comb begin
        in_win   = (bus_addr[PAGE_SHIFT-1:4] == '0);
        off      = reg_off_e'(bus_addr[3:2]);
        page     = bus_addr[ADDR_W-1:PAGE_SHIFT];
        soft_clr = bus_wdata & SOFT_MASK;
        if (bus_wdata[ALIAS_BIT]) soft_clr[DATA_W-1] = 1'b1;
        hw_bit   = DATA_W'(1) << hw_level;

        for (int c = 0; c < NUM_CPU; c++) begin
            set_m[c] = '0;
            clr_m[c] = '0;
            if (bus_wr && in_win && (page == CPU_W'(c))) begin
                case (off)
                    OFF_SET: set_m[c] = bus_wdata & SOFT_MASK;
                    OFF_CLR: clr_m[c] = soft_clr;
                    default: ;
                endcase
            end
            // hardware bits (1..15) never overlap the soft field (17..31)
            if (hw_valid && (hw_cpu == CPU_W'(c)) && (hw_level != '0)) begin
                if (hw_assert) set_m[c] = set_m[c] | hw_bit;
                else           clr_m[c] = clr_m[c] | hw_bit;
            end
        end

        bus_d = bus_q;
        if (bus_rd)
            bus_d.rdata = (in_win && off == OFF_PEND) ? pend_w[page] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_rdata = bus_q.rdata;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        sirq_cpu_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_mask  (set_m[g]),
            .clr_mask  (clr_m[g]),
            .ack       (irq_ack[g]),
            .pend      (pend_w[g]),
            .req_valid (irq_valid[g]),
            .req_level (irq_level[g*LVL_W +: LVL_W])
        );
    end

    a_r2_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr[3:2] != 2'd0)) |=> (bus_rdata == '0));
    a_r5_outside_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr[PAGE_SHIFT-1:4] != '0)) |=> (bus_rdata == '0));
    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/softirq_bank_tb_top.sv
module softirq_bank_tb_top;
    localparam int NC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [15:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_valid = 0, hw_assert = 0;
    logic [3:0]  hw_cpu = '0, hw_level = '0;
    logic [NC-1:0]   irq_ack = '0;
    logic [NC-1:0]   irq_valid;
    logic [NC*4-1:0] irq_level;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_pend [NC];
    logic        m_busy [NC];
    logic [31:0] e_rdata;
    logic [NC-1:0]   e_valid;
    logic [NC*4-1:0] e_level;

    always #4 clk = ~clk;

    softirq_bank dut_i (.*);

    function automatic logic [3:0] soft_lvl(logic [31:0] p);
        logic [3:0] l = 0;
        for (int b = 17; b < 32; b++) if (p[b]) l = 4'(b - 16);
        return l;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle from a negedge, update the model at the edge, compare at the next negedge
    task automatic step(bit rd, bit wr, logic [15:0] addr, logic [31:0] wd,
                        bit hv, bit ha, logic [3:0] hc, logic [3:0] hl, logic [NC-1:0] ack);
        logic [31:0] cm;
        bit win;
        bus_rd = rd; bus_wr = wr; bus_addr = addr[15:2]; bus_wdata = wd;
        hw_valid = hv; hw_assert = ha; hw_cpu = hc; hw_level = hl; irq_ack = ack;
        @(posedge clk);
        win = (addr[11:4] == 0);
        for (int c = 0; c < NC; c++) begin
            logic [3:0] l = soft_lvl(m_pend[c]);
            e_valid[c] = (l != 0) && !m_busy[c];
            e_level[c*4 +: 4] = e_valid[c] ? l : 4'd0;
            m_busy[c] = e_valid[c] | (m_busy[c] & ~ack[c]);
        end
        if (rd) e_rdata = (win && addr[3:2] == 0) ? m_pend[addr[15:12]] : 32'd0;
        if (wr && win && addr[3:2] == 2) m_pend[addr[15:12]] |= wd & 32'hFFFE0000;
        if (wr && win && addr[3:2] == 1) begin
            cm = wd & 32'hFFFE0000;
            if (wd[14]) cm[31] = 1'b1;
            m_pend[addr[15:12]] &= ~cm;
        end
        if (hv && hl != 0) begin
            if (ha) m_pend[hc][hl] = 1'b1;
            else    m_pend[hc][hl] = 1'b0;
        end
        @(negedge clk);
        chk(irq_valid == e_valid, "R8 request strobes", 64'(irq_valid), 64'(e_valid));
        chk(irq_level == e_level, "R7 request levels", irq_level, e_level);
        chk(bus_rdata == e_rdata, "R2 read data", 64'(bus_rdata), 64'(e_rdata));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic rd_expect(int cpu, logic [31:0] exp, string tag);
        step(1, 0, 16'(cpu << 12), 0, 0, 0, 0, 0, '0);
        chk(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < NC; c++) begin m_pend[c] = 0; m_busy[c] = 0; end
        e_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_rdata == 0 && irq_valid == 0, "R1 reset outputs", 64'({bus_rdata, irq_valid}), 64'd0);
        rd_expect(9, 32'd0, "R1 reset register zero");

        // R3 set through offset 2, R10 strobe the cycle after
        step(0, 1, 16'h3008, 32'hFFFF_FFFF, 0, 0, 0, 0, '0);
        chk(irq_valid[3] == 0, "R10 no strobe at write edge", 64'(irq_valid[3]), 64'd0);
        step(0, 0, 0, 0, 0, 0, 0, 0, '0);
        chk(irq_valid[3] && irq_level[15:12] == 15, "R10 strobe level 15", 64'(irq_level[15:12]), 64'd15);
        rd_expect(3, 32'hFFFE_0000, "R3 set masked to bits 31..17");
        rd_expect(4, 32'd0, "R11 neighbour untouched");

        // R4 bit-14 alias clears bit 31 only
        step(0, 1, 16'h3004, 32'h0000_4000, 0, 0, 0, 0, '0);
        rd_expect(3, 32'h7FFE_0000, "R4 alias clears bit 31");
        step(0, 1, 16'h3004, 32'h7FFF_FFFF, 0, 0, 0, 0, '0);
        rd_expect(3, 32'h0, "R4 clear masked bits");
        step(0, 0, 0, 0, 0, 0, 0, 0, 16'h0008);

        // R5 ignored writes and out-of-window access
        step(0, 1, 16'h5000, 32'hFFFF_FFFF, 0, 0, 0, 0, '0);
        step(0, 1, 16'h500C, 32'hFFFF_FFFF, 0, 0, 0, 0, '0);
        step(0, 1, 16'h5018, 32'hFFFF_FFFF, 0, 0, 0, 0, '0);
        rd_expect(5, 32'd0, "R5 writes ignored");
        step(0, 1, 16'h5008, 32'h0010_0000, 0, 0, 0, 0, '0);
        step(1, 0, 16'h5010, 0, 0, 0, 0, 0, '0);
        chk(bus_rdata == 0, "R5 out-of-window read zero", 64'(bus_rdata), 64'd0);
        step(1, 0, 16'h5004, 0, 0, 0, 0, 0, '0);
        chk(bus_rdata == 0, "R2 offset 1 reads zero", 64'(bus_rdata), 64'd0);
        chk(irq_level[23:20] == 0, "R7 level idle zero", 64'(irq_level[23:20]), 64'd0);

        // R6 hardware levels; they never request (R7)
        step(0, 0, 0, 0, 1, 1, 4'd7, 4'd5, '0);
        step(0, 0, 0, 0, 1, 1, 4'd7, 4'd0, '0);
        rd_expect(7, 32'h0000_0020, "R6 hw set, level 0 ignored");
        chk(irq_valid[7] == 0, "R7 low bits no request", 64'(irq_valid[7]), 64'd0);
        step(0, 0, 0, 0, 1, 0, 4'd7, 4'd5, '0);
        rd_expect(7, 32'd0, "R6 hw clear");

        // R7 priority, R8 gating, R9 re-issue after ack
        step(0, 1, 16'h9008, 32'h0012_0000, 0, 0, 0, 0, '0);
        step(0, 0, 0, 0, 0, 0, 0, 0, '0);
        chk(irq_level[39:36] == 4, "R7 highest bit 20 gives 4", 64'(irq_level[39:36]), 64'd4);
        idle(3);
        chk(irq_valid[9] == 0, "R8 no repeat before ack", 64'(irq_valid[9]), 64'd0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 16'h0200);
        step(0, 0, 0, 0, 0, 0, 0, 0, '0);
        chk(irq_valid[9] == 1, "R9 re-issue after ack", 64'(irq_valid[9]), 64'd1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            a = {4'($urandom % 4), (($urandom % 10) == 0) ? 8'($urandom) : 8'd0,
                 2'($urandom), 2'b00};
            step(($urandom % 2) == 0, ($urandom % 5) < 2, a, $urandom,
                 ($urandom % 3) == 0, $urandom % 2, 4'($urandom % 4), 4'($urandom),
                 NC'($urandom & $urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule